// File: doc/BRIEF.md
# Command-Driven Status and Error Flag Register

This block holds the status flags of a serial controller and the small set of configuration fields that sit beside them. Software can read the flags as one status word but can never write them directly. Every change goes through a separate write-only command register. In that register, each flag owns one bit that sets it and one bit that clears it. One command write may touch any number of flags at once.

Eight flags are kept. The run flag selects between configuration mode (cleared) and operational mode (set). The master-select flag chooses the controller role. Six error flags cover mode, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. The shift engine and the FIFOs report five of these errors as single-cycle event pulses. Each event is gated by its own detection-enable bit in the control register. One error interrupt is high while any of the six error flags is set.

Width, clock-mode and baud fields accept writes only in configuration mode. The detection-enable bits may be changed at any time. The status word also shows a live busy input from the engine.

Top module: `sscr_status_ctrl`

## Requirements
- R1: After reset all flags, control fields and the baud field read 0, and op_enable, master_sel and err_irq are low.
- R2: Register word addresses are: 0 control (read/write), 1 status (read-only), 2 command (write-only, reads 0), 3 baud (read/write). Status bit positions are: run 0, master-select 1, mode error 7, transmit overflow 8, receive overflow 9, abort 10, transmit underflow 11, receive underflow 12, and busy_i in bit 13. All other status bits read 0.
- R3: In a command write, bit 0 clears the run flag, bit 1 sets it, bit 2 clears master-select and bit 3 sets it. The new value appears one cycle after the write on op_enable, on master_sel and in the status word.
- R4: Command bit pairs for the errors (clear/set) are: receive underflow 4/5, mode error 6/7, transmit overflow 8/12, receive overflow 9/13, abort 10/14, transmit underflow 11/15.
- R5: A single command write applies every set and clear bit it carries to its own flag.
- R6: When one command write carries both the set bit and the clear bit of a flag, that flag keeps its value.
- R7: An event pulse sets its error flag on the next cycle while its detection enable is 1. The enables sit in control bits 8 (transmit overflow), 9 (receive overflow), 10 (abort), 11 (transmit underflow) and 12 (receive underflow).
- R8: An event pulse whose detection enable is 0 leaves the flags and err_irq unchanged.
- R9: An enabled event pulse in the same cycle as a command clear of that flag leaves the flag set.
- R10: err_irq is high exactly while at least one of the six error flags is set. The run and master-select flags do not drive it.
- R11: The control register holds the word width minus one in bits 4:0 and the clock mode in bits 6:5. These fields and the baud register take writes only while the run flag is 0; writes made while it is 1 are ignored. The detection-enable bits in control bits 12:8 are written in either mode.
- R12: A write to the status address changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as a read strobe |
| busy_i | input | 1 | Engine busy, shown in status bit 13 |
| ev_tx_over | input | 1 | Transmit overflow event pulse |
| ev_rx_over | input | 1 | Receive overflow event pulse |
| ev_abort | input | 1 | Abort event pulse |
| ev_tx_under | input | 1 | Transmit underflow event pulse |
| ev_rx_under | input | 1 | Receive underflow event pulse |
| op_enable | output | 1 | Run flag: 1 = operational mode |
| master_sel | output | 1 | Master-select flag |
| err_irq | output | 1 | Error interrupt |
| cfg_width_m1 | output | 5 | Word width minus one |
| cfg_clk_mode | output | 2 | Clock mode |
| cfg_baud | output | BAUD_W | Baud divider |

## Verification
The assertions check several rules on every cycle. A set-only or clear-only command on the run flag takes effect one cycle later, and a command carrying both bits leaves the flag as it was. An enabled transmit overflow event raises the interrupt on the next cycle. The width and clock-mode outputs hold still when the control register is written in operational mode. The interrupt cannot rise without a command write or an enabled event. Other behaviours need the bench's scenarios to show them: the full command-bit-to-status-bit map across many flags and multi-flag writes, masked events, an event racing a software clear, the busy bit, the baud lock, and readback of the write-only and read-only addresses.

// File: rtl/sscr_pkg.sv
package sscr_pkg;

    localparam int unsigned NFLAG = 8;
    localparam int unsigned NEV   = 5;

    // word addresses
    localparam int unsigned A_CTRL = 0;
    localparam int unsigned A_STAT = 1;
    localparam int unsigned A_CMD  = 2;
    localparam int unsigned A_BAUD = 3;

    // flag order: run, master, mode err, tx over, rx over, abort, tx under, rx under
    localparam int unsigned FLAG_POS [NFLAG] = '{0, 1, 7, 8, 9, 10, 11, 12};
    localparam int unsigned FLAG_SET [NFLAG] = '{1, 3, 7, 12, 13, 14, 15, 5};
    localparam int unsigned FLAG_CLR [NFLAG] = '{0, 2, 6, 8, 9, 10, 11, 4};
    localparam bit          FLAG_HW  [NFLAG] = '{0, 0, 0, 1, 1, 1, 1, 1};
    localparam int unsigned FLAG_EV  [NFLAG] = '{0, 0, 0, 0, 1, 2, 3, 4};

    localparam int unsigned BUSY_POS   = 13;
    localparam int unsigned ERR_EN_LSB = 8;
    localparam int unsigned FIRST_ERR  = 2;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_cmd;
        logic wr_baud;
        logic wr_stat;
        logic rd_ctrl;
        logic rd_stat;
        logic rd_baud;
    } dec_t;

endpackage

// File: rtl/sscr_bus_decode.sv
module sscr_bus_decode
    import sscr_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] AC = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AS = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AM = ADDR_W'(A_CMD);
    localparam logic [ADDR_W-1:0] AB = ADDR_W'(A_BAUD);

    logic wr, rd;

    always_comb begin
        wr = bus_sel & bus_we;
        rd = bus_sel & ~bus_we;
        dec.wr_ctrl = wr & (bus_addr == AC);
        dec.wr_stat = wr & (bus_addr == AS);
        dec.wr_cmd  = wr & (bus_addr == AM);
        dec.wr_baud = wr & (bus_addr == AB);
        dec.rd_ctrl = rd & (bus_addr == AC);
        dec.rd_stat = rd & (bus_addr == AS);
        dec.rd_baud = rd & (bus_addr == AB);
    end
endmodule

// File: rtl/sscr_flag_cell.sv
module sscr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic hw_ev,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (hw_ev)
            q_d = 1'b1;               // hardware event wins over a clear
        else if (set_cmd && !clr_cmd)
            q_d = 1'b1;
        else if (clr_cmd && !set_cmd)
            q_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/sscr_status_ctrl.sv
module sscr_status_ctrl
    import sscr_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy_i,
    input  logic              ev_tx_over,
    input  logic              ev_rx_over,
    input  logic              ev_abort,
    input  logic              ev_tx_under,
    input  logic              ev_rx_under,
    output logic              op_enable,
    output logic              master_sel,
    output logic              err_irq,
    output logic [4:0]        cfg_width_m1,
    output logic [1:0]        cfg_clk_mode,
    output logic [BAUD_W-1:0] cfg_baud
);
    localparam int unsigned CTRL_W = ERR_EN_LSB + NEV;

    typedef struct packed {
        logic [4:0]        width_m1;
        logic [1:0]        clk_mode;
        logic [NEV-1:0]    err_en;
        logic [BAUD_W-1:0] baud;
    } cfg_t;

    dec_t             dec;
    cfg_t             cfg_d, cfg_q;
    logic [NFLAG-1:0] flags;
    logic [NEV-1:0]   hw_ev;
    logic [NEV-1:0]   err_en_w;
    logic [DATA_W-1:0] stat_word;
    logic [CTRL_W-1:0] ctrl_word;

    assign hw_ev    = {ev_rx_under, ev_tx_under, ev_abort, ev_rx_over, ev_tx_over};
    assign err_en_w = cfg_q.err_en;

    sscr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .dec      (dec)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic ev_in;
        if (FLAG_HW[i]) begin : g_hw
            assign ev_in = hw_ev[FLAG_EV[i]] & cfg_q.err_en[FLAG_EV[i]];
        end else begin : g_sw
            assign ev_in = 1'b0;
        end
        sscr_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_cmd (dec.wr_cmd & bus_wdata[FLAG_SET[i]]),
            .clr_cmd (dec.wr_cmd & bus_wdata[FLAG_CLR[i]]),
            .hw_ev   (ev_in),
            .q       (flags[i])
        );
    end

    // next configuration
    always_comb begin
        cfg_d = cfg_q;
        if (dec.wr_ctrl) begin
            cfg_d.err_en = bus_wdata[ERR_EN_LSB +: NEV];
            if (!flags[0]) begin
                cfg_d.width_m1 = bus_wdata[4:0];
                cfg_d.clk_mode = bus_wdata[6:5];
            end
        end
        if (dec.wr_baud && !flags[0])
            cfg_d.baud = bus_wdata[BAUD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // read side
    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NFLAG; i++)
            stat_word[FLAG_POS[i]] = flags[i];
        stat_word[BUSY_POS] = busy_i;
        ctrl_word = {cfg_q.err_en, 1'b0, cfg_q.clk_mode, cfg_q.width_m1};
        bus_rdata = '0;
        if (dec.rd_ctrl) bus_rdata = DATA_W'(ctrl_word);
        if (dec.rd_stat) bus_rdata = stat_word;
        if (dec.rd_baud) bus_rdata = DATA_W'(cfg_q.baud);
    end

    assign op_enable    = flags[0];
    assign master_sel   = flags[1];
    assign err_irq      = |flags[NFLAG-1:FIRST_ERR];
    assign cfg_width_m1 = cfg_q.width_m1;
    assign cfg_clk_mode = cfg_q.clk_mode;
    assign cfg_baud     = cfg_q.baud;

    logic unused_stat_wr;
    assign unused_stat_wr = dec.wr_stat;   // status address is read-only
endmodule

// File: rtl/sscr_status_ctrl_chk.sv
module sscr_status_ctrl_chk
    import sscr_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NEV-1:0]    hw_ev,
    input logic [NEV-1:0]    err_en_w,
    input logic              op_enable,
    input logic              err_irq,
    input logic [4:0]        cfg_width_m1,
    input logic [1:0]        cfg_clk_mode
);
    logic cmd_wr, ctrl_wr;
    assign cmd_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(A_CMD));
    assign ctrl_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(A_CTRL));

    assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[1] && !bus_wdata[0] |=> op_enable);

    assert_enable_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[0] && !bus_wdata[1] |=> !op_enable);

    assert_pair_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && bus_wdata[0] && bus_wdata[1] |=> op_enable == $past(op_enable));

    assert_event_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ev[0] && err_en_w[0] |=> err_irq);

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && op_enable |=> $stable(cfg_width_m1) && $stable(cfg_clk_mode));

    // R8 and R10: interrupt rises only from a command or an enabled event
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_irq && !cmd_wr && ((hw_ev & err_en_w) == '0) |=> !err_irq);
endmodule

bind sscr_status_ctrl sscr_status_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .hw_ev        (hw_ev),
    .err_en_w     (err_en_w),
    .op_enable    (op_enable),
    .err_irq      (err_irq),
    .cfg_width_m1 (cfg_width_m1),
    .cfg_clk_mode (cfg_clk_mode)
);

// File: tb/tb_sscr_status_ctrl.sv
`timescale 1ns/1ps
module tb_sscr_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        busy_i = 1'b0;
    logic        ev_tx_over = 1'b0, ev_rx_over = 1'b0, ev_abort = 1'b0;
    logic        ev_tx_under = 1'b0, ev_rx_under = 1'b0;
    logic        op_enable, master_sel, err_irq;
    logic [4:0]  cfg_width_m1;
    logic [1:0]  cfg_clk_mode;
    logic [15:0] cfg_baud;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sscr_status_ctrl dut (.*);

    // {command, expected status} walked from the reset state (R3 R4 R5 R6)
    localparam logic [31:0] VEC [14] = '{
        {16'h0002, 16'h0001}, {16'h0008, 16'h0003}, {16'h0020, 16'h1003},
        {16'h0080, 16'h1083}, {16'hF000, 16'h1F83}, {16'h0010, 16'h0F83},
        {16'h0F00, 16'h0083}, {16'h0040, 16'h0003}, {16'h0003, 16'h0003},
        {16'h1100, 16'h0003}, {16'h2004, 16'h0201}, {16'h0001, 16'h0200},
        {16'h0200, 16'h0000}, {16'h00C0, 16'h0000}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    // event pulses {rx_under, tx_under, abort, rx_over, tx_over}, optional command write
    task automatic pulse(logic [4:0] ev, logic do_cmd, logic [15:0] cmd);
        @(negedge clk);
        {ev_rx_under, ev_tx_under, ev_abort, ev_rx_over, ev_tx_over} = ev;
        if (do_cmd) begin bus_sel = 1; bus_we = 1; bus_addr = 2'd2; bus_wdata = cmd; end
        @(negedge clk);
        {ev_rx_under, ev_tx_under, ev_abort, ev_rx_over, ev_tx_over} = '0;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(2'd1, d); check("R1 status", d, 0);
        rd(2'd0, d); check("R1 ctrl", d, 0);
        rd(2'd3, d); check("R1 baud", d, 0);
        check("R1 outputs", {op_enable, master_sel, err_irq}, 0);

        foreach (VEC[i]) begin
            wr(2'd2, VEC[i][31:16]);
            rd(2'd1, d);
            check($sformatf("R4 R5 R6 vector %0d status", i), d, VEC[i][15:0]);
            check($sformatf("R10 vector %0d irq", i), err_irq, |(VEC[i][15:0] & 16'h1F80));
            check($sformatf("R3 vector %0d run/master", i), {op_enable, master_sel},
                  {VEC[i][0], VEC[i][1]});
        end

        // R2 busy bit and address map
        busy_i = 1; rd(2'd1, d); check("R2 busy bit", d, 16'h2000); busy_i = 0;
        wr(2'd2, 16'h0008);
        rd(2'd2, d); check("R2 command reads zero", d, 0);
        // R12 status address ignores writes
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check("R12 status write ignored", d, 16'h0002);
        wr(2'd2, 16'h0004);

        // R11 config in configuration mode
        wr(2'd0, 16'h0047); wr(2'd3, 16'h1234);
        rd(2'd0, d); check("R11 ctrl written", d, 16'h0047);
        check("R11 config ports", {cfg_width_m1, cfg_clk_mode, cfg_baud}, {5'd7, 2'd2, 16'h1234});
        wr(2'd2, 16'h0002);
        wr(2'd0, 16'h0015); wr(2'd3, 16'hABCD);
        rd(2'd0, d); check("R11 ctrl locked", d, 16'h0047);
        rd(2'd3, d); check("R11 baud locked", d, 16'h1234);

        // R8 masked events
        pulse(5'h1F, 0, 0);
        rd(2'd1, d); check("R8 masked status", d, 16'h0001);
        check("R8 masked irq", err_irq, 0);

        // R7 enabled events (enables writable while operational)
        wr(2'd0, 16'h1F00);
        rd(2'd0, d); check("R11 enables written", d, 16'h1F47);
        pulse(5'h01, 0, 0);
        rd(2'd1, d); check("R7 tx overflow", d, 16'h0101);
        check("R10 irq on", err_irq, 1);
        pulse(5'h10, 0, 0);
        rd(2'd1, d); check("R7 rx underflow", d, 16'h1101);
        wr(2'd2, 16'h0110);
        rd(2'd1, d); check("R5 clear two", d, 16'h0001);
        check("R10 irq off", err_irq, 0);

        // R9 event beats clear
        pulse(5'h04, 1, 16'h0400);
        rd(2'd1, d); check("R9 event wins", d, 16'h0401);
        wr(2'd2, 16'h0400);
        rd(2'd1, d); check("R9 later clear", d, 16'h0001);

        // R10 run/master do not raise irq
        wr(2'd2, 16'h0008);
        check("R10 no irq from run/master", {op_enable, master_sel, err_irq}, 3'b110);

        // back to configuration mode, config writable again
        wr(2'd2, 16'h0005);
        wr(2'd0, 16'h0003);
        rd(2'd0, d); check("R11 unlocked", d, 16'h0003);
        rd(2'd1, d); check("R3 both cleared", d, 0);

        summary();
    end
endmodule